// File: doc/BRIEF.md
# Contactless Reply Hold-off Timer

This block decides when a card-emulating transmitter may begin its answer to a command it has just received from a reader. When the receive path signals the end of a reader frame, the timer classifies the command. A polling command answered as a tag waits out a collision window. That window is a fixed base number of ticks plus one slot length for each slot number, where one tick is `TICK_DIV` enabled carrier cycles. Any other command, or the same command in no-delay or reader operation, is released on the next clock.

Once released, the block raises a transmit permit towards the byte source and produces a bit-rate strobe. The byte source shifts one reply bit per strobe. The strobe comes from the same phase counter that paces the hold-off, so reply bits run at the receive bit rate. The strobe fires every `TICK_DIV` carrier cycles at the low rate and at twice that rate when the high-rate input is set. The byte source ends the reply with a last-byte pulse.

The carrier enable, the end-of-frame strobe and the last-byte pulse are single-cycle control strobes with no handshake. There is no data path through the block, so there is no valid/ready interface and no back-pressure. Holding `carrier_en` low simply stalls all timing.

Top module: `rsp_slot_timer`

## Requirements
- R1: After reset `tx_permit`, `busy` and `bit_stb` are low.
- R2: A polling command (`is_poll`=1, `nodelay`=0, `reader_mode`=0) with slot 0 raises `tx_permit` exactly `BASE_TICKS*TICK_DIV` clocks after the clock that samples `eof_stb`, when `carrier_en` is high every cycle.
- R3: For slot number N, the polling hold-off is `(BASE_TICKS + N*SLOT_TICKS)*TICK_DIV` clocks. The slot value is captured with `eof_stb`.
- R4: A non-polling command raises `tx_permit` on the clock that samples `eof_stb`, whatever the slot number.
- R5: With `nodelay`=1 a polling command is released on the clock that samples `eof_stb`.
- R6: With `reader_mode`=1 the polling flag has no effect, and the release is immediate.
- R7: An `eof_stb` that arrives while the hold-off is still counting restarts the count from zero, using the newly presented command inputs.
- R8: While `tx_permit` is high, `bit_stb` pulses once every `TICK_DIV` enabled carrier cycles when `rate_hi`=0, and once every `TICK_DIV/2` when `rate_hi`=1. It stays low while `tx_permit` is low.
- R9: A `last_done` pulse while `tx_permit` is high drops `tx_permit` and `busy` on the next clock. A `last_done` pulse during the hold-off is ignored.
- R10: `busy` is high from the clock that samples `eof_stb` until `tx_permit` falls.
- R11: Timing advances only on cycles with `carrier_en` high. With it held low, a pending hold-off never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_en | input | 1 | One pulse per carrier cycle |
| eof_stb | input | 1 | End of received reader frame |
| is_poll | input | 1 | Received command is a polling command |
| slot_num | input | SLOT_W | Time slot for the polling answer |
| nodelay | input | 1 | Bypass the collision hold-off |
| reader_mode | input | 1 | Reader operation instead of tag operation |
| rate_hi | input | 1 | 1 selects the doubled bit rate |
| last_done | input | 1 | Byte source has sent the final reply byte |
| tx_permit | output | 1 | Transmitter may shift reply bits |
| bit_stb | output | 1 | One reply bit period elapsed |
| busy | output | 1 | A reply is pending or in progress |

## Verification
The bench builds the timer with `TICK_DIV`=4, `BASE_TICKS`=8, `SLOT_TICKS`=4 and `SLOT_W`=2. With these values every slot, including the largest (80 clocks), completes within a hundred cycles. Exact latencies can therefore be checked for all four slots, for restart, and for both strobe rates. The shortened window still keeps both the tick and the slot compare paths multi-step, so off-by-one errors in either counter change the measured latency.

// File: rtl/rst_pkg.sv
package rst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } rst_state_t;
endpackage

// File: rtl/rst_phase_ctr.sv
// Shared carrier phase counter: paces hold-off ticks and reply bit periods.
module rst_phase_ctr #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic clr,
  output logic tick,
  output logic half_tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] MID  = PW'(DIV / 2 - 1);

  logic [PW-1:0] phase;

  assign tick      = ce && (phase == LAST);
  assign half_tick = ce && (phase == MID);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase <= '0;
    else if (ce)       phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/rst_wait_ctr.sv
// Counts hold-off ticks and flags the tick that completes the window.
module rst_wait_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = en && !clr && tick && (cnt == target - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (en && tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rsp_slot_timer.sv
module rsp_slot_timer
  import rst_pkg::*;
#(
  parameter int TICK_DIV   = 64,
  parameter int BASE_TICKS = 512,
  parameter int SLOT_TICKS = 256,
  parameter int SLOT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_en,
  input  logic              eof_stb,
  input  logic              is_poll,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic              nodelay,
  input  logic              reader_mode,
  input  logic              rate_hi,
  input  logic              last_done,
  output logic              tx_permit,
  output logic              bit_stb,
  output logic              busy
);
  localparam int MAX_TICKS = BASE_TICKS + ((1 << SLOT_W) - 1) * SLOT_TICKS;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  rst_state_t    state;
  logic [CW-1:0] target;
  logic          accept, immediate, tick, half_tick, win_done;

  assign accept    = eof_stb && (state != ST_SEND);
  assign immediate = !is_poll || nodelay || reader_mode;

  rst_phase_ctr #(.DIV(TICK_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .ce(carrier_en), .clr(accept),
    .tick(tick), .half_tick(half_tick)
  );

  rst_wait_ctr #(.CW(CW)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(state == ST_WAIT),
    .tick(tick), .target(target), .done(win_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      target <= '0;
    end else if (accept) begin
      state  <= immediate ? ST_SEND : ST_WAIT;
      target <= CW'(BASE_TICKS) + CW'(slot_num) * CW'(SLOT_TICKS);
    end else begin
      case (state)
        ST_WAIT: if (win_done)  state <= ST_SEND;
        ST_SEND: if (last_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_permit = (state == ST_SEND);
  assign busy      = (state != ST_IDLE);

  generate
    if (TICK_DIV >= 2) begin : g_dual_rate
      assign bit_stb = tx_permit && (tick || (rate_hi && half_tick));
    end else begin : g_single_rate
      assign bit_stb = tx_permit && tick;
    end
  endgenerate
endmodule

// File: rtl/rsp_slot_timer_chk.sv
module rsp_slot_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic carrier_en,
  input logic eof_stb,
  input logic is_poll,
  input logic nodelay,
  input logic reader_mode,
  input logic last_done,
  input logic tx_permit,
  input logic busy
);
  assert_permit_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> busy);

  assert_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_stb && !tx_permit && (!is_poll || nodelay || reader_mode)) |=> tx_permit);

  assert_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_stb && !tx_permit && is_poll && !nodelay && !reader_mode) |=> (!tx_permit && busy));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && last_done) |=> (!tx_permit && !busy));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_en && !eof_stb && !tx_permit) |=> !tx_permit);
endmodule

bind rsp_slot_timer rsp_slot_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .carrier_en(carrier_en), .eof_stb(eof_stb),
  .is_poll(is_poll), .nodelay(nodelay), .reader_mode(reader_mode),
  .last_done(last_done), .tx_permit(tx_permit), .busy(busy)
);

// File: tb/rsp_slot_timer_tb_top.sv
module rsp_slot_timer_tb_top;
  localparam int DIV = 4, BASE = 8, SLOT = 4, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic carrier_en = 1'b1, eof_stb = 1'b0, is_poll = 1'b0, nodelay = 1'b0;
  logic reader_mode = 1'b0, rate_hi = 1'b0, last_done = 1'b0;
  logic [SW-1:0] slot_num = '0;
  logic tx_permit, bit_stb, busy;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  rsp_slot_timer #(.TICK_DIV(DIV), .BASE_TICKS(BASE), .SLOT_TICKS(SLOT), .SLOT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_en(carrier_en), .eof_stb(eof_stb),
    .is_poll(is_poll), .slot_num(slot_num), .nodelay(nodelay),
    .reader_mode(reader_mode), .rate_hi(rate_hi), .last_done(last_done),
    .tx_permit(tx_permit), .bit_stb(bit_stb), .busy(busy)
  );

  // {poll, nodelay, reader, slot, expected latency in clocks}
  typedef struct packed {
    logic poll; logic nd; logic rd; logic [1:0] slot; logic [11:0] lat;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 2'd0, 12'd32},  // R2 base window
    '{1'b1, 1'b0, 1'b0, 2'd1, 12'd48},  // R3 slot 1
    '{1'b1, 1'b0, 1'b0, 2'd2, 12'd64},  // R3 slot 2
    '{1'b1, 1'b0, 1'b0, 2'd3, 12'd80},  // R3 slot 3
    '{1'b0, 1'b0, 1'b0, 2'd0, 12'd0},   // R4 non-polling
    '{1'b0, 1'b0, 1'b0, 2'd3, 12'd0},   // R4 slot ignored
    '{1'b1, 1'b1, 1'b0, 2'd3, 12'd0},   // R5 no-delay bypass
    '{1'b1, 1'b0, 1'b1, 2'd2, 12'd0}    // R6 reader mode
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic send_eof(input logic p, input logic nd, input logic rd, input logic [SW-1:0] s);
    @(negedge clk);
    is_poll = p; nodelay = nd; reader_mode = rd; slot_num = s; eof_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eof_stb = 1'b0;
  endtask

  task automatic measure(output int lat);
    lat = 0;
    while (!tx_permit && lat < 2000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
  endtask

  task automatic finish_reply(input string req);
    last_done = 1'b1;
    @(posedge clk); @(negedge clk);
    last_done = 1'b0;
    chk(!tx_permit && !busy, req, {30'd0, tx_permit, busy}, 0);
  endtask

  task automatic count_stb(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      if (bit_stb) hits++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    int lat, hits;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!tx_permit && !busy && !bit_stb, "R1 reset", {29'd0, tx_permit, busy, bit_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_permit && !busy, "R1 after release", {30'd0, tx_permit, busy}, 0);

    for (int v = 0; v < NV; v++) begin
      send_eof(VEC[v].poll, VEC[v].nd, VEC[v].rd, VEC[v].slot);
      chk(busy, "R10 busy after eof", int'(busy), 1);
      measure(lat);
      chk(lat == int'(VEC[v].lat), $sformatf("R2/R3/R4/R5/R6 vector %0d latency", v), lat, int'(VEC[v].lat));
      finish_reply("R9 release");
    end

    // R7: restart while counting
    send_eof(1'b1, 1'b0, 1'b0, 2'd1);
    repeat (20) begin @(posedge clk); @(negedge clk); end
    chk(!tx_permit && busy, "R7 still waiting", int'(tx_permit), 0);
    send_eof(1'b1, 1'b0, 1'b0, 2'd0);
    measure(lat);
    chk(lat == 32, "R7 restart latency", lat, 32);

    // R8: strobe rates while permitted
    rate_hi = 1'b0;
    count_stb(16, hits);
    chk(hits == 4, "R8 low rate strobes", hits, 4);
    rate_hi = 1'b1;
    count_stb(16, hits);
    chk(hits == 8, "R8 high rate strobes", hits, 8);
    finish_reply("R9 release after strobes");
    count_stb(16, hits);
    chk(hits == 0, "R8 no strobe without permit", hits, 0);
    rate_hi = 1'b0;

    // R11 stall and R9 ignored during hold-off
    send_eof(1'b1, 1'b0, 1'b0, 2'd0);
    carrier_en = 1'b0;
    repeat (200) begin @(posedge clk); @(negedge clk); end
    chk(!tx_permit && busy, "R11 stalled without carrier", int'(tx_permit), 0);
    last_done = 1'b1;
    @(posedge clk); @(negedge clk);
    last_done = 1'b0;
    chk(busy && !tx_permit, "R9 last_done ignored in hold-off", int'(busy), 1);
    carrier_en = 1'b1;
    measure(lat);
    chk(lat == 32, "R11 resumes with full window", lat, 32);
    finish_reply("R9 final release");

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule